// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block merges the completion pulses of up to sixteen DMA channels into a single interrupt request for the processor. Bits 0 to 11 each belong to one fixed source: SD card read and write, three pairs of SPI read and write, a camera threshold event, a camera FIFO-empty event, and audio serial port read and write. Bits 15:12 carry the completions of four ADC channels. A one-cycle pulse on a source input latches a pending flag. That flag stays set until software clears it. A per-source mask decides whether the pending flag reaches the interrupt line.

Software reaches the block through a simple register port with a combinational read. It can load the whole mask at once, or change single mask bits through set-only and clear-only aliases, so that no read-modify-write is needed. Pending flags are cleared per bit with a write-1 acknowledge, or all at once through a flush register that ignores its data. Both the raw pending view and the masked view can be read, and reading changes nothing.

Top module: `dma_done_irq_agg`

## Requirements
- R1: After synchronous reset every mask bit is 1, every pending bit is 0, and `irq_o` is 0.
- R2: A 1 on `evt_i[b]` at a rising clock edge sets pending bit b. The bit then stays set with no further events. Raw status at offset 0xA4 shows the pending bits in data bits [15:0] whatever the mask.
- R3: A write to offset 0x8C loads the mask from data bits [15:0], and offset 0x8C reads the mask back. A mask bit of 1 blocks its source and 0 lets it through.
- R4: A write to offset 0x90 sets each mask bit whose data bit is 1 and leaves the bits written with 0 unchanged.
- R5: A write to offset 0x94 clears each mask bit whose data bit is 1 and leaves the bits written with 0 unchanged.
- R6: A write to offset 0x9C clears each pending bit whose data bit is 1 and leaves the bits written with 0 pending.
- R7: Any write to offset 0x98, including data 0, clears every pending bit.
- R8: Masked status at offset 0xA0 reads 1 in bit b only when pending bit b is 1 and mask bit b is 0.
- R9: `irq_o` is 1 exactly when some source is both pending and unmasked. This applies to the ADC bits 15:12 as well.
- R10: When a source event and an acknowledge or flush of the same bit fall in the same cycle, the bit is pending afterwards.
- R11: Reading any offset leaves the mask, the pending bits and `irq_o` unchanged.
- R12: Writes to the status offsets 0xA0 and 0xA4 have no effect. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | SRC_N (16) | One-cycle DMA completion pulses, one per source |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe, acts at the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets collisions between an event and a clear of the same bit. A design that lets the clear win there drops a completion for good, and raw status shows the bit as 0. Zero-data writes to the set, clear and acknowledge aliases must change nothing. A design that treats an alias as a plain store would wipe the mask or the pending bits. A flush written with data 0 must still clear everything; a design that gates the flush on the data would leave the bits pending. Repeated status reads and writes to the read-only offsets are checked, so a read-to-clear or a writable status register shows up as lost or changed bits.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_MASK     = 8'h8C;
    localparam logic [ADDR_W-1:0] OFS_MASK_SET = 8'h90;
    localparam logic [ADDR_W-1:0] OFS_MASK_CLR = 8'h94;
    localparam logic [ADDR_W-1:0] OFS_FLUSH    = 8'h98;
    localparam logic [ADDR_W-1:0] OFS_ACK      = 8'h9C;
    localparam logic [ADDR_W-1:0] OFS_MASKED   = 8'hA0;
    localparam logic [ADDR_W-1:0] OFS_RAW      = 8'hA4;

    typedef struct packed {
        logic mask_load;
        logic mask_set;
        logic mask_clr;
        logic pend_flush;
        logic pend_ack;
    } wr_strobe_t;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_MASK,
        RSEL_MASKED,
        RSEL_RAW
    } rsel_e;

    function automatic rsel_e rsel_of(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_MASK:   return RSEL_MASK;
            OFS_MASKED: return RSEL_MASKED;
            OFS_RAW:    return RSEL_RAW;
            default:    return RSEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dmairq_decode.sv
module dmairq_decode
    import dmairq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output wr_strobe_t        stb,
    output rsel_e             rsel
);

    always_comb begin
        stb            = '0;
        stb.mask_load  = wr && (addr == OFS_MASK);
        stb.mask_set   = wr && (addr == OFS_MASK_SET);
        stb.mask_clr   = wr && (addr == OFS_MASK_CLR);
        stb.pend_flush = wr && (addr == OFS_FLUSH);
        stb.pend_ack   = wr && (addr == OFS_ACK);
        rsel           = rsel_of(addr);
    end

endmodule

// File: rtl/dmairq_mask_bank.sv
module dmairq_mask_bank
    import dmairq_pkg::*;
#(
    parameter int unsigned SRC_N = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_strobe_t       stb,
    input  logic [SRC_N-1:0] wdata,
    output logic [SRC_N-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '1;
        else if (stb.mask_load)
            mask_q <= wdata;
        else if (stb.mask_set)
            mask_q <= mask_q | wdata;
        else if (stb.mask_clr)
            mask_q <= mask_q & ~wdata;
    end

    AST_MASK_SET_ONLY: assert property (@(posedge clk) disable iff (rst)
        stb.mask_set |=> ((mask_q & $past(wdata)) == $past(wdata))
                         && ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata)))); // R4
    AST_MASK_CLR_ONLY: assert property (@(posedge clk) disable iff (rst)
        stb.mask_clr |=> ((mask_q & $past(wdata)) == '0)
                         && ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata)))); // R5
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(stb.mask_load || stb.mask_set || stb.mask_clr) |=> $stable(mask_q)); // R12

endmodule

// File: rtl/dmairq_pend_bank.sv
module dmairq_pend_bank
    import dmairq_pkg::*;
#(
    parameter int unsigned SRC_N = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] evt,
    input  wr_strobe_t       stb,
    input  logic [SRC_N-1:0] wdata,
    output logic [SRC_N-1:0] pend_q
);

    for (genvar b = 0; b < SRC_N; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend_q[b] <= 1'b0;
            else if (evt[b])
                pend_q[b] <= 1'b1;
            else if (stb.pend_flush || (stb.pend_ack && wdata[b]))
                pend_q[b] <= 1'b0;
        end
    end

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((pend_q & $past(evt)) == $past(evt))); // R10
    AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (rst)
        (stb.pend_flush && !(|evt)) |=> (pend_q == '0)); // R7
    AST_ACK_BITS: assert property (@(posedge clk) disable iff (rst)
        stb.pend_ack |=> ((pend_q & $past(wdata & ~evt)) == '0)); // R6
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(|evt || stb.pend_flush || stb.pend_ack) |=> $stable(pend_q)); // R2

endmodule

// File: rtl/dma_done_irq_agg.sv
module dma_done_irq_agg
    import dmairq_pkg::*;
#(
    parameter int unsigned SRC_N  = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  evt_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    wr_strobe_t       stb;
    rsel_e            rsel;
    logic [SRC_N-1:0] mask_q;
    logic [SRC_N-1:0] pend_q;
    logic [SRC_N-1:0] live;

    dmairq_decode u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .stb  (stb),
        .rsel (rsel)
    );

    dmairq_mask_bank #(.SRC_N(SRC_N)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .stb    (stb),
        .wdata  (bus_wdata[SRC_N-1:0]),
        .mask_q (mask_q)
    );

    dmairq_pend_bank #(.SRC_N(SRC_N)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_i),
        .stb    (stb),
        .wdata  (bus_wdata[SRC_N-1:0]),
        .pend_q (pend_q)
    );

    assign live  = pend_q & ~mask_q;
    assign irq_o = |live;

    always_comb begin
        case (rsel)
            RSEL_MASK:   bus_rdata = DATA_W'(mask_q);
            RSEL_MASKED: bus_rdata = DATA_W'(live);
            RSEL_RAW:    bus_rdata = DATA_W'(pend_q);
            default:     bus_rdata = '0;
        endcase
    end

    AST_IRQ_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |-> !irq_o); // R9
    AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && !(|evt_i)) |=> ($stable(pend_q) && $stable(mask_q))); // R11

endmodule

// File: tb/dma_done_irq_agg_test.sv
module dma_done_irq_agg_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] evt_i = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dma_done_irq_agg uut (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt_i),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [15:0] ev);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; evt_i = ev;
        @(negedge clk);
        bus_wr = 1'b0; evt_i = '0;
    endtask

    task automatic pulse(input logic [15:0] ev);
        @(negedge clk);
        evt_i = ev;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h8C, d); check("R1 mask after reset", d, 32'h0000_FFFF);
        rd(8'hA4, d); check("R1 raw after reset", d, 32'h0);
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_event;
        logic [31:0] d;
        pulse(16'h0005);
        rd(8'hA4, d); check("R2 raw after event", d, 32'h0005);
        check("R9 irq low while masked", {31'b0, irq_o}, 32'h0);
        repeat (3) @(negedge clk);
        rd(8'hA4, d); check("R2 raw held", d, 32'h0005);
    endtask

    task automatic t_mask_load;
        logic [31:0] d;
        wr(8'h8C, 32'hFFFF_FFFE, '0);
        rd(8'h8C, d); check("R3 mask load", d, 32'h0000_FFFE);
        rd(8'hA0, d); check("R8 masked status", d, 32'h0001);
        check("R9 irq on unmasked pending", {31'b0, irq_o}, 32'h1);
    endtask

    task automatic t_mask_set;
        logic [31:0] d;
        wr(8'h90, 32'h0000_0001, '0);
        rd(8'h8C, d); check("R4 set alias", d, 32'h0000_FFFF);
        check("R9 irq drops when masked", {31'b0, irq_o}, 32'h0);
        wr(8'h8C, 32'h0000_00F0, '0);
        wr(8'h90, 32'h0, '0);
        rd(8'h8C, d); check("R4 set alias zero data", d, 32'h0000_00F0);
        wr(8'h8C, 32'h0000_FFFF, '0);
    endtask

    task automatic t_mask_clr;
        logic [31:0] d;
        wr(8'h94, 32'h0000_0004, '0);
        rd(8'h8C, d); check("R5 clear alias", d, 32'h0000_FFFB);
        rd(8'hA0, d); check("R8 masked after clear alias", d, 32'h0004);
        wr(8'h94, 32'h0, '0);
        rd(8'h8C, d); check("R5 clear alias zero data", d, 32'h0000_FFFB);
    endtask

    task automatic t_ack;
        logic [31:0] d;
        wr(8'h9C, 32'h0000_0004, '0);
        rd(8'hA4, d); check("R6 ack one bit", d, 32'h0001);
        check("R9 irq after ack", {31'b0, irq_o}, 32'h0);
        wr(8'h9C, 32'h0, '0);
        rd(8'hA4, d); check("R6 ack zero data", d, 32'h0001);
    endtask

    task automatic t_adc_and_flush;
        logic [31:0] d;
        pulse(16'hF000);
        wr(8'h94, 32'h0000_8000, '0);
        check("R9 irq from ADC bit", {31'b0, irq_o}, 32'h1);
        rd(8'hA4, d); check("R2 raw with ADC bits", d, 32'hF001);
        wr(8'h98, 32'h0, '0);
        rd(8'hA4, d); check("R7 flush with zero data", d, 32'h0);
        check("R7 irq after flush", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        pulse(16'h0008);
        wr(8'h9C, 32'h0000_0008, 16'h0008);
        rd(8'hA4, d); check("R10 event beats ack", d, 32'h0008);
        wr(8'h98, 32'hFFFF_FFFF, 16'h8000);
        rd(8'hA4, d); check("R10 event beats flush", d, 32'h8000);
    endtask

    task automatic t_reads;
        logic [31:0] d;
        for (int i = 0; i < 4; i++) rd(8'hA4, d);
        check("R11 raw after repeated reads", d, 32'h8000);
        rd(8'hA0, d); rd(8'hA0, d);
        check("R11 masked after repeated reads", d, 32'h8000);
        check("R11 irq after reads", {31'b0, irq_o}, 32'h1);
        wr(8'hA4, 32'h0, '0);
        wr(8'hA0, 32'hFFFF_FFFF, '0);
        rd(8'hA4, d); check("R12 raw write ignored", d, 32'h8000);
        rd(8'h8C, d); check("R12 mask untouched by status write", d, 32'h0000_7FFB);
        rd(8'h10, d); check("R12 unmapped read zero", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_event();
        t_mask_load();
        t_mask_set();
        t_mask_clr();
        t_ack();
        t_adc_and_flush();
        t_collide();
        t_reads();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule